// File: doc/BRIEF.md
# PSRAM Configuration and Power-Mode Sequencer

This block sits on the host side of an asynchronous pseudo-SRAM. It handles every bus operation that is not an array access. It waits out the power-up interval after reset. It writes and reads back the device's configuration word through the sleep-select pin. It puts the device into deep power-down and brings it back out again. A small command port takes four operations: load the configuration, read the configuration, enter power-down and wake. Each accepted command produces exactly one response, which either carries a result or flags an error.

The chip-enable, output-enable, write-enable, sleep-select, byte-enable and address pins are shared with the normal access controller. Before it drives any of them, the sequencer raises `busReq`. It drives them only while `busGnt` is held. The access controller may start array cycles only while `acAllow` is high. A request it raises while the device is powered down or recovering is refused through `acErr`.

A shadow copy of the last configuration value written is kept inside the block. That copy decides whether the next chip-enable rising edge puts the device to sleep. The power-down bit is armed when it reads 0.

Top module: `psram_seq`

## Requirements
- R1: For PWRUP_CYC cycles after reset, `cmdReady` and `acAllow` stay low and `ceN` stays high. `cmdReady` rises within PWRUP_CYC+2 cycles of reset release.
- R2: Command code 0 (load) requests the bus. Once granted, it drives `zzN`, `ceN` and `weN` low, with `oeN` high and `addr` equal to the command data, for exactly PULSE_CYC cycles. It then raises `ceN` for one cycle with `zzN` still low, and responds with no error.
- R3: Command code 1 (read) drives `zzN`, `ceN`, `oeN`, `lbN` and `ubN` low, with `weN` high, for PULSE_CYC cycles. It samples `dqIn` in the last low cycle and returns that value on `rspData`.
- R4: Bit 4 of the configuration word arms power-down when it is 0. The power-down state is entered at the first sequencer chip-enable rising edge that follows completion of an arming load. The load's own rising edge does not enter it, and a read's rising edge does. Command code 2 (enter) makes a PULSE_CYC chip-enable pulse with `zzN`, `weN` and `oeN` high.
- R5: The following commands are answered with `rspErr` set and cause no chip-enable activity: wake (code 3) outside power-down, load, read or enter inside power-down, and enter while the shadow is not armed.
- R6: `acAllow` is high only when the sequencer is idle and outside power-down or recovery, and never while `busReq` is high. `acErr` is high in the cycle after any cycle where `acReq` was high and `acAllow` low.
- R7: Wake drives `ceN` low with `zzN` high for exactly DPDX_CYC cycles. The bus is then released and RECOV_CYC more cycles pass before the response arrives and `acAllow` returns.
- R8: The shadow word is CR_DEFAULT after reset and again after a wake completes. Otherwise it changes only when a load completes.
- R9: `ceN` stays high and `seqDrive` low whenever `busGnt` is not held. `busReq` stays high from the request until the final chip-enable-high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 2 | 0 load, 1 read, 2 enter power-down, 3 wake |
| cmdData | input | ADDR_W | Configuration value for a load |
| cmdReady | output | 1 | Sequencer idle, command taken when valid |
| rspValid | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Response refused |
| rspData | output | DATA_W | Configuration read result |
| busReq | output | 1 | Sequencer wants the shared pins |
| busGnt | input | 1 | Access controller has released the pins |
| seqDrive | output | 1 | Sequencer pin values are active |
| acReq | input | 1 | Access controller wants to start an array cycle |
| acAllow | output | 1 | Array cycles permitted |
| acErr | output | 1 | Access request refused |
| ceN | output | 1 | Chip enable, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| zzN | output | 1 | Sleep/config select, active low |
| lbN | output | 1 | Lower byte enable, active low |
| ubN | output | 1 | Upper byte enable, active low |
| addr | output | ADDR_W | Address pins carrying the configuration value |
| dqIn | input | DATA_W | Data bus from the device |

## Verification
The checker watches several properties on every cycle:

- chip enable held high through the power-up window;
- no strobe without a grant;
- `acAllow` never overlapping a bus request;
- write pulses always carrying sleep-select low and output-enable high;
- read pulses always carrying the byte strobes and write-enable in their read levels;
- refused access requests tracing back to a request.

Some behaviour can only be shown by the bench's scenarios. These include exact pulse widths, the value latched by a device model at the chip-enable rise, and the read data returned. They also cover the arming rule, where a load's own edge does not enter power-down but a later edge does, the error replies, and the recovery gap and shadow reset after a wake.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_READ  = 2'd1,
    OP_ENTER = 2'd2,
    OP_WAKE  = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_REQ,
    ST_ACT,
    ST_END,
    ST_RCV
  } seq_state_e;

  // Strobes from control to datapath, all active high.
  typedef struct packed {
    logic take;     // latch command data
    logic ce;       // chip enable asserted
    logic we;       // write enable asserted
    logic oe;       // output enable asserted
    logic zz;       // sleep/config select asserted
    logic be;       // byte enables asserted
    logic cap;      // capture read data
    logic commit;   // update shadow from latched data
    logic restore;  // shadow back to default
  } seq_strb_t;

endpackage

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
  import psram_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 18750,
  parameter int PULSE_CYC = 8,
  parameter int DPDX_CYC  = 1250,
  parameter int RECOV_CYC = 1875
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  seq_op_e   cmdOp,
  input  logic      shadowArmed,
  input  logic      busGnt,
  input  logic      acReq,
  output logic      cmdReady,
  output logic      busReq,
  output logic      seqDrive,
  output logic      acAllow,
  output logic      acErr,
  output logic      rspValid,
  output logic      rspErr,
  output seq_strb_t strb
);

  localparam int MAX_A = (PWRUP_CYC > DPDX_CYC) ? PWRUP_CYC : DPDX_CYC;
  localparam int MAX_B = (RECOV_CYC > PULSE_CYC) ? RECOV_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] PLS_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] DPX_LD = CNT_W'(DPDX_CYC - 1);
  localparam logic [CNT_W-1:0] RCV_LD = CNT_W'(RECOV_CYC - 1);

  seq_state_e       st;
  seq_op_e          opReg;
  logic [CNT_W-1:0] cnt;
  logic             dpd;
  logic             reqBad;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  // Refusal rule for a newly offered command.
  always_comb begin
    if (dpd) reqBad = (cmdOp != OP_WAKE);
    else     reqBad = (cmdOp == OP_WAKE) || ((cmdOp == OP_ENTER) && !shadowArmed);
  end

  assign cmdReady = (st == ST_IDLE);
  assign busReq   = (st == ST_REQ) || (st == ST_ACT) || (st == ST_END);
  assign seqDrive = (st == ST_ACT) || (st == ST_END);
  assign acAllow  = (st == ST_IDLE) && !dpd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_PWR;
      opReg    <= OP_LOAD;
      cnt      <= PWR_LD;
      dpd      <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      acErr    <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      acErr    <= acReq && !acAllow;
      case (st)
        ST_PWR: begin
          if (cntZero) st <= ST_IDLE;
          else         cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (cmdValid) begin
            opReg <= cmdOp;
            if (reqBad) begin
              rspValid <= 1'b1;
              rspErr   <= 1'b1;
            end else begin
              st <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (busGnt) begin
            st  <= ST_ACT;
            cnt <= (opReg == OP_WAKE) ? DPX_LD : PLS_LD;
          end
        end
        ST_ACT: begin
          if (cntZero) st <= ST_END;
          else         cnt <= cnt - 1'b1;
        end
        ST_END: begin
          if (opReg == OP_WAKE) begin
            st  <= ST_RCV;
            cnt <= RCV_LD;
          end else begin
            st       <= ST_IDLE;
            rspValid <= 1'b1;
            // Shadow still holds the value from before this edge.
            if (shadowArmed) dpd <= 1'b1;
          end
        end
        ST_RCV: begin
          if (cntZero) begin
            st       <= ST_IDLE;
            dpd      <= 1'b0;
            rspValid <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.take    = (st == ST_IDLE) && cmdValid;
    strb.restore = (st == ST_RCV) && cntZero;
    if (st == ST_ACT) begin
      strb.ce = 1'b1;
      case (opReg)
        OP_LOAD: begin
          strb.we = 1'b1;
          strb.zz = 1'b1;
        end
        OP_READ: begin
          strb.oe  = 1'b1;
          strb.zz  = 1'b1;
          strb.be  = 1'b1;
          strb.cap = cntZero;
        end
        default: ;
      endcase
    end else if (st == ST_END) begin
      strb.zz     = (opReg == OP_LOAD) || (opReg == OP_READ);
      strb.commit = (opReg == OP_LOAD);
    end
  end

endmodule

// File: rtl/psram_seq_dp.sv
module psram_seq_dp
  import psram_seq_pkg::*;
#(
  parameter int                ADDR_W     = 22,
  parameter int                DATA_W     = 16,
  parameter int                DPD_BIT    = 4,
  parameter logic [ADDR_W-1:0] CR_DEFAULT = 22'h000070
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strb_t         strb,
  input  logic [ADDR_W-1:0] cmdData,
  input  logic [DATA_W-1:0] dqIn,
  output logic              shadowArmed,
  output logic [DATA_W-1:0] rspData,
  output logic              ceN,
  output logic              weN,
  output logic              oeN,
  output logic              zzN,
  output logic              lbN,
  output logic              ubN,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] cmdLatch;
  logic [ADDR_W-1:0] shadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLatch <= '0;
      shadow   <= CR_DEFAULT;
      rspData  <= '0;
    end else begin
      if (strb.take)    cmdLatch <= cmdData;
      if (strb.commit)  shadow   <= cmdLatch;
      if (strb.restore) shadow   <= CR_DEFAULT;
      if (strb.cap)     rspData  <= dqIn;
    end
  end

  assign shadowArmed = !shadow[DPD_BIT];

  assign ceN  = !strb.ce;
  assign weN  = !strb.we;
  assign oeN  = !strb.oe;
  assign zzN  = !strb.zz;
  assign lbN  = !strb.be;
  assign ubN  = !strb.be;
  assign addr = (strb.ce || strb.zz) ? cmdLatch : '0;

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_seq_pkg::*;
#(
  parameter int                ADDR_W     = 22,
  parameter int                DATA_W     = 16,
  parameter int                DPD_BIT    = 4,
  parameter logic [ADDR_W-1:0] CR_DEFAULT = 22'h000070,
  parameter int                PWRUP_CYC  = 18750,
  parameter int                PULSE_CYC  = 8,
  parameter int                DPDX_CYC   = 1250,
  parameter int                RECOV_CYC  = 1875
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdData,
  output logic              cmdReady,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic              busReq,
  input  logic              busGnt,
  output logic              seqDrive,
  input  logic              acReq,
  output logic              acAllow,
  output logic              acErr,
  output logic              ceN,
  output logic              weN,
  output logic              oeN,
  output logic              zzN,
  output logic              lbN,
  output logic              ubN,
  output logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn
);

  seq_strb_t strb;
  logic      shadowArmed;

  psram_seq_ctrl #(
    .PWRUP_CYC(PWRUP_CYC), .PULSE_CYC(PULSE_CYC),
    .DPDX_CYC(DPDX_CYC),   .RECOV_CYC(RECOV_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(seq_op_e'(cmdOp)),
    .shadowArmed(shadowArmed), .busGnt(busGnt), .acReq(acReq),
    .cmdReady(cmdReady), .busReq(busReq), .seqDrive(seqDrive),
    .acAllow(acAllow), .acErr(acErr), .rspValid(rspValid), .rspErr(rspErr),
    .strb(strb)
  );

  psram_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DPD_BIT(DPD_BIT), .CR_DEFAULT(CR_DEFAULT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdData(cmdData), .dqIn(dqIn),
    .shadowArmed(shadowArmed), .rspData(rspData),
    .ceN(ceN), .weN(weN), .oeN(oeN), .zzN(zzN), .lbN(lbN), .ubN(ubN), .addr(addr)
  );

endmodule

// File: rtl/psram_seq_chk.sv
module psram_seq_chk #(
  parameter int PWRUP_CYC = 18750
) (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic busReq,
  input logic busGnt,
  input logic seqDrive,
  input logic acReq,
  input logic acAllow,
  input logic acErr,
  input logic rspValid,
  input logic rspErr,
  input logic ceN,
  input logic weN,
  input logic oeN,
  input logic zzN,
  input logic lbN,
  input logic ubN
);

  logic [31:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       upCnt <= '0;
    else if (upCnt < 32'(PWRUP_CYC)) upCnt <= upCnt + 1'b1;
  end

  a_r1_ce_high_powerup: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt < 32'(PWRUP_CYC)) |-> (ceN && !cmdReady && !acAllow));

  a_r9_drive_needs_gnt: assert property (@(posedge clk) disable iff (!rstN)
    seqDrive |-> busGnt);

  a_r9_parked_pins: assert property (@(posedge clk) disable iff (!rstN)
    !seqDrive |-> (ceN && zzN && weN && oeN));

  a_r6_allow_not_req: assert property (@(posedge clk) disable iff (!rstN)
    acAllow |-> !busReq);

  a_r6_err_traces_req: assert property (@(posedge clk) disable iff (!rstN)
    acErr |-> $past(acReq));

  a_r2_write_levels: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN) |-> (!zzN && oeN));

  a_r3_read_levels: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN) |-> (!zzN && weN && !lbN && !ubN));

  a_r7_pulse_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && zzN) |-> (weN && oeN));

  a_r5_err_is_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

endmodule

bind psram_seq psram_seq_chk #(.PWRUP_CYC(PWRUP_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .busReq(busReq), .busGnt(busGnt),
  .seqDrive(seqDrive), .acReq(acReq), .acAllow(acAllow), .acErr(acErr),
  .rspValid(rspValid), .rspErr(rspErr), .ceN(ceN), .weN(weN), .oeN(oeN),
  .zzN(zzN), .lbN(lbN), .ubN(ubN)
);

// File: tb/psram_seq_tb.sv
module psram_seq_tb;

  localparam int PW = 200;
  localparam int PL = 4;
  localparam int DX = 40;
  localparam int RC = 12;
  localparam logic [21:0] CRDEF = 22'h000070;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [21:0] cmdData = '0;
  logic        cmdReady, rspValid, rspErr, busReq, seqDrive, acAllow, acErr;
  logic [15:0] rspData, dqIn;
  logic        busGnt = 1'b0;
  logic        acReq = 1'b0;
  logic        ceN, weN, oeN, zzN, lbN, ubN;
  logic [21:0] addr;

  psram_seq #(
    .CR_DEFAULT(CRDEF), .PWRUP_CYC(PW), .PULSE_CYC(PL), .DPDX_CYC(DX), .RECOV_CYC(RC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdReady(cmdReady), .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .busReq(busReq), .busGnt(busGnt), .seqDrive(seqDrive), .acReq(acReq),
    .acAllow(acAllow), .acErr(acErr), .ceN(ceN), .weN(weN), .oeN(oeN), .zzN(zzN),
    .lbN(lbN), .ubN(ubN), .addr(addr), .dqIn(dqIn)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  int relCyc = 1 << 30;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Device model driven only by the pins.
  logic [21:0] mCr = CRDEF;
  bit          mDpd = 0;
  int          ceLow = 0, lastPulse = 0, riseCyc = 0, earlyCe = 0, gntViol = 0;
  logic        prevCe = 1'b1, prevWr = 1'b0;
  logic [21:0] prevAddr = '0;

  assign dqIn = (!ceN && !zzN && !oeN) ? mCr[15:0] : 16'hFFFF;

  always @(posedge clk) begin
    if (rstN) begin
      if (!ceN) ceLow <= ceLow + 1;
      if (!ceN && cyc < relCyc + PW) earlyCe <= earlyCe + 1;
      if (busReq && !busGnt && !ceN) gntViol <= gntViol + 1;
      if (!prevCe && ceN) begin
        lastPulse <= ceLow;
        riseCyc   <= cyc;
        ceLow     <= 0;
        if (mDpd) begin
          if (ceLow >= DX) begin
            mDpd <= 0;
            mCr  <= CRDEF;
          end
        end else begin
          if (!mCr[4]) mDpd <= 1;
          if (prevWr)  mCr  <= prevAddr;
        end
      end
      prevCe   <= ceN;
      prevWr   <= !ceN && !weN && !zzN;
      prevAddr <= addr;
    end
  end

  // Grant responder with adjustable delay.
  int gDelay = 2;
  int gCnt = 0;
  always @(posedge clk) begin
    if (!busReq) begin
      busGnt <= 1'b0;
      gCnt   <= 0;
    end else if (gCnt >= gDelay) begin
      busGnt <= 1'b1;
    end else begin
      gCnt <= gCnt + 1;
    end
  end

  // Scoreboard.
  typedef struct {
    bit          err;
    bit          chk;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t q[$];
  exp_t cur;
  int   lastRspCyc = 0;

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (q.size() == 0) begin
        check(1'b0, "R5", "unexpected response", 1, 0);
      end else begin
        cur = q.pop_front();
        check(rspErr == cur.err, cur.req, "rspErr", longint'(rspErr), longint'(cur.err));
        if (cur.chk)
          check(rspData == cur.data, cur.req, "rspData", longint'(rspData), longint'(cur.data));
      end
      lastRspCyc = cyc;
    end
  end

  task automatic doCmd(input logic [1:0] op, input logic [21:0] d, input bit err,
                       input bit chk, input logic [15:0] ed, input string req);
    exp_t e;
    e.err = err; e.chk = chk; e.data = ed; e.req = req;
    q.push_back(e);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  localparam logic [21:0] V1 = 22'h12A5F3;  // bit4 = 1
  localparam logic [21:0] V2 = 22'h0345B7;  // bit4 = 1
  localparam logic [21:0] V3 = 22'h00ABE6;  // bit4 = 0, arms power-down

  initial begin
    int n;
    int riseBefore;
    repeat (5) @(negedge clk);
    check(cmdReady == 0, "R1", "cmdReady in reset", cmdReady, 0);
    check(ceN == 1, "R1", "ceN in reset", ceN, 1);
    check(busReq == 0, "R9", "busReq in reset", busReq, 0);
    rstN = 1'b1;
    relCyc = cyc;
    @(negedge clk);
    check(acAllow == 0, "R1", "acAllow during power-up", acAllow, 0);
    n = 1;
    while (!cmdReady) begin @(negedge clk); n++; end
    check(n >= PW && n <= PW + 2, "R1", "power-up wait cycles", n, PW);
    check(earlyCe == 0, "R1", "ceN low during power-up", earlyCe, 0);
    check(acAllow == 1, "R6", "acAllow when idle", acAllow, 1);

    @(negedge clk) acReq = 1'b1;
    @(negedge clk) acReq = 1'b0;
    check(acErr == 0, "R6", "acErr while allowed", acErr, 0);

    doCmd(2'd0, V1, 0, 0, '0, "R2");
    check(mCr == V1, "R2", "device config after load", mCr, V1);
    check(lastPulse == PL, "R2", "load pulse width", lastPulse, PL);

    doCmd(2'd1, '0, 0, 1, V1[15:0], "R3");

    gDelay = 6;
    doCmd(2'd0, V2, 0, 0, '0, "R9");
    check(gntViol == 0, "R9", "strobes before grant", gntViol, 0);
    check(mCr == V2, "R2", "device config after delayed grant", mCr, V2);
    gDelay = 2;

    riseBefore = riseCyc;
    doCmd(2'd2, '0, 1, 0, '0, "R5");
    check(riseCyc == riseBefore, "R5", "no CE pulse on unarmed enter", riseCyc, riseBefore);
    doCmd(2'd3, '0, 1, 0, '0, "R5");
    check(mDpd == 0, "R5", "device awake after refused wake", mDpd, 0);

    doCmd(2'd0, V3, 0, 0, '0, "R4");
    check(mCr == V3, "R4", "arming value loaded", mCr, V3);
    check(mDpd == 0, "R4", "load edge does not sleep", mDpd, 0);

    doCmd(2'd2, '0, 0, 0, '0, "R4");
    check(mDpd == 1, "R4", "device asleep after enter", mDpd, 1);
    check(lastPulse == PL, "R4", "enter pulse width", lastPulse, PL);
    check(acAllow == 0, "R6", "acAllow in power-down", acAllow, 0);
    @(negedge clk) acReq = 1'b1;
    @(negedge clk) acReq = 1'b0;
    check(acErr == 1, "R6", "acErr in power-down", acErr, 1);

    riseBefore = riseCyc;
    doCmd(2'd1, '0, 1, 0, '0, "R5");
    check(riseCyc == riseBefore, "R5", "no CE pulse on refused read", riseCyc, riseBefore);

    doCmd(2'd3, '0, 0, 0, '0, "R7");
    check(mDpd == 0, "R7", "device awake after wake", mDpd, 0);
    check(lastPulse == DX, "R7", "wake pulse width", lastPulse, DX);
    check(lastRspCyc - riseCyc >= RC, "R7", "recovery gap", lastRspCyc - riseCyc, RC);
    check(acAllow == 1, "R7", "acAllow after recovery", acAllow, 1);

    doCmd(2'd2, '0, 1, 0, '0, "R8");
    check(mCr == CRDEF, "R8", "device config default after wake", mCr, CRDEF);

    doCmd(2'd0, V3, 0, 0, '0, "R4");
    doCmd(2'd1, '0, 0, 1, V3[15:0], "R4");
    check(mDpd == 1, "R4", "read edge enters power-down when armed", mDpd, 1);
    doCmd(2'd3, '0, 0, 0, '0, "R7");
    check(mDpd == 0, "R7", "second wake", mDpd, 0);

    finishRun();
  end

endmodule